// File: doc/BRIEF.md
# Debug-side multi-channel serial mailbox

This block connects a debugger's register bus to a set of byte-wide, full-duplex channels that face a processor core. The number of channels is a parameter from 0 to 8. Each channel has two queues. One carries bytes from the debugger to the core, and the other carries bytes from the core to the debugger. Each queue is 4 entries deep and 8 bits wide.

The debugger reaches the channels through three registers. A control/status register holds a channel select field, a read-only channel count and per-channel status bits. A transmit register pushes a byte toward the core. A receive register pops the oldest byte that the core sent. The select field picks which channel the transmit and receive registers act on.

On the core side, every channel has a plain push/pop FIFO port with full and empty flags. A sticky error flag on each channel records any overflow or underflow. While that flag is set, every transmit or receive access from the debugger to that channel fails. The flag stays set until the debugger writes 1 to its bit.

The register bus completes each access in the same cycle it is presented. Read data and an error-response signal are driven combinationally from the current state, and state changes take effect at the next rising clock edge.

Top module: `dbgmbx_top`

## Requirements

- R1: A read of the control/status register reports the following. Address 0 is the control/status register. Bits [31:28] hold the channel count NUM_CH. Bits [26:24] hold the select value taken from bits [26:24] of the most recent write to address 0. Reads and writes of address 0 never give an error response.
- R2: In the control/status read, each channel c reports three bits:
  - Bit c is its error flag.
  - Bit 8+c is 1 when its core-to-debugger queue holds at least one byte.
  - Bit 16+c is 1 when its debugger-to-core queue holds 4 bytes.
  - The bits of channels c >= NUM_CH read 0.
- R3: A write to address 1 (transmit) with the selected channel's error flag clear and its debugger-to-core queue not full behaves as follows. It appends write-data bits [7:0] to that queue and gives no error response. The core then receives the bytes in write order on coreRdata, which shows the oldest byte while coreEmpty is 0, through corePop.
- R4: A transmit write fails when the selected channel's debugger-to-core queue is full or its error flag is set. A failed write queues nothing, sets the error flag and gives an error response.
- R5: A read of address 1 returns, zero-extended, bits [7:0] of the most recent transmit write, including a failed write. The value is 0 after reset, and the read gives no error response.
- R6: A read of address 2 (receive) with the selected channel's error flag clear and its core-to-debugger queue not empty behaves as follows. It returns the oldest byte in bits [7:0] with the upper bits 0, removes that byte, and gives no error response.
- R7: A receive read fails when the selected channel's core-to-debugger queue is empty or its error flag is set. A failed read returns 0, removes nothing, sets the error flag and gives an error response.
- R8: Writing 1 to bit c of the control/status register clears channel c's error flag, and writing 0 there leaves it unchanged. When an error event on that channel occurs in the same cycle as the clear, the flag stays set.
- R9: A core push into a full core-to-debugger queue is dropped, and a core pop from an empty debugger-to-core queue removes nothing. Either case sets that channel's error flag.
- R10: Several accesses give an error response and change no queue or error flag:
  - a transmit write or receive read while the select value is NUM_CH or more;
  - any access to address 1 or 2 when NUM_CH is 0;
  - any write to address 2;
  - any access to address 3.
- R11: Reset empties every queue, clears every error flag and sets the select value to 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrite | input | 1 | Register write strobe (takes priority over regRead) |
| regRead | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address: 0 control/status, 1 transmit, 2 receive, 3 unmapped |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for the current access, 0 when not a successful read |
| regErr | output | 1 | Error response for the current access |
| corePush | input | max(NUM_CH,1) | Per-channel push into the core-to-debugger queue |
| coreWdata | input | max(NUM_CH,1)*DATA_W | Per-channel push data, channel c in slice c*DATA_W |
| corePop | input | max(NUM_CH,1) | Per-channel pop from the debugger-to-core queue |
| coreRdata | output | max(NUM_CH,1)*DATA_W | Per-channel oldest debugger-to-core byte |
| coreEmpty | output | max(NUM_CH,1) | Per-channel debugger-to-core queue empty |
| coreFull | output | max(NUM_CH,1) | Per-channel core-to-debugger queue full |

## Verification

The assertions check, on every cycle, the relations that a single cycle or a pair of cycles can show:
- a rejected transmit write to a full or flagged channel answers with an error and raises the flag on the next cycle;
- a failed receive read carries zero data;
- an error flag drops only where a write of 1 cleared it;
- a core overflow sets its flag;
- the count field matches NUM_CH, and the status bits agree with the core-side full and empty flags;
- accesses to a missing channel fail.

Only the bench's scenarios can show the rest, which needs history over many cycles:
- that bytes come out in the order they went in;
- that a failed access leaves a queue untouched;
- that the transmit readback returns the last written value;
- that a set event wins over a clear in the same cycle;
- that a reset in the middle of a run empties queues that were holding data;
- the behaviour of a zero-channel build.

// File: rtl/dbgmbx_pkg.sv
package dbgmbx_pkg;

  localparam int MAX_CH   = 8;
  localparam int REG_W    = 32;
  localparam int SEL_W    = 3;
  localparam int CNT_W    = 4;
  localparam int ERR_LSB  = 0;
  localparam int VAL_LSB  = 8;
  localparam int FULL_LSB = 16;
  localparam int SEL_LSB  = 24;
  localparam int CNT_LSB  = 28;

  typedef enum logic [1:0] {
    A_CSR  = 2'd0,
    A_TX   = 2'd1,
    A_RX   = 2'd2,
    A_NONE = 2'd3
  } regAddr_e;

  // one-hot strobes from control to datapath
  typedef struct packed {
    logic [MAX_CH-1:0] d2cPush;
    logic [MAX_CH-1:0] c2dPop;
  } chStrobe_t;

endpackage

// File: rtl/dbgmbx_fifo.sv
module dbgmbx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pop,
  output logic [DATA_W-1:0] rdData,
  output logic              full,
  output logic              empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count;
  logic              doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

endmodule

// File: rtl/dbgmbx_data.sv
module dbgmbx_data import dbgmbx_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int CHP    = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  chStrobe_t                      strb,
  input  logic [DATA_W-1:0]              pushData,
  input  logic [CHP-1:0]                 corePush,
  input  logic [CHP*DATA_W-1:0]          coreWdata,
  input  logic [CHP-1:0]                 corePop,
  output logic [CHP*DATA_W-1:0]          coreRdata,
  output logic [CHP-1:0]                 coreEmpty,
  output logic [CHP-1:0]                 coreFull,
  output logic [MAX_CH-1:0]              d2cFull,
  output logic [MAX_CH-1:0]              c2dEmpty,
  output logic [MAX_CH-1:0][DATA_W-1:0]  c2dHead,
  output logic [MAX_CH-1:0]              coreErrEvt
);

  for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
    if (c < NUM_CH) begin : g_on
      logic d2cEmpty, c2dFull;

      dbgmbx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_d2c (
        .clk    (clk),
        .rstN   (rstN),
        .push   (strb.d2cPush[c]),
        .wrData (pushData),
        .pop    (corePop[c]),
        .rdData (coreRdata[c*DATA_W +: DATA_W]),
        .full   (d2cFull[c]),
        .empty  (d2cEmpty)
      );

      dbgmbx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_c2d (
        .clk    (clk),
        .rstN   (rstN),
        .push   (corePush[c]),
        .wrData (coreWdata[c*DATA_W +: DATA_W]),
        .pop    (strb.c2dPop[c]),
        .rdData (c2dHead[c]),
        .full   (c2dFull),
        .empty  (c2dEmpty[c])
      );

      assign coreEmpty[c]  = d2cEmpty;
      assign coreFull[c]   = c2dFull;
      assign coreErrEvt[c] = (corePush[c] && c2dFull) || (corePop[c] && d2cEmpty);
    end else begin : g_off
      assign d2cFull[c]    = 1'b0;
      assign c2dEmpty[c]   = 1'b1;
      assign c2dHead[c]    = '0;
      assign coreErrEvt[c] = 1'b0;
    end
  end

  if (NUM_CH == 0) begin : g_none
    logic unusedCore;
    assign coreEmpty  = '1;
    assign coreFull   = '0;
    assign coreRdata  = '0;
    assign unusedCore = ^{corePush, coreWdata, corePop, strb, pushData};
  end

endmodule

// File: rtl/dbgmbx_ctrl.sv
module dbgmbx_ctrl import dbgmbx_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrite,
  input  logic                           regRead,
  input  logic [1:0]                     regAddr,
  input  logic [REG_W-1:0]               regWdata,
  output logic [REG_W-1:0]               regRdata,
  output logic                           regErr,
  input  logic [MAX_CH-1:0]              d2cFull,
  input  logic [MAX_CH-1:0]              c2dEmpty,
  input  logic [MAX_CH-1:0][DATA_W-1:0]  c2dHead,
  input  logic [MAX_CH-1:0]              coreErrEvt,
  output chStrobe_t                      strb,
  output logic [DATA_W-1:0]              pushData,
  output logic [MAX_CH-1:0]              errBits,
  output logic [SEL_W-1:0]               selReg
);

  localparam logic [MAX_CH-1:0] CH_MASK = MAX_CH'((1 << NUM_CH) - 1);
  localparam logic [CNT_W-1:0]  CNT_VAL = CNT_W'(NUM_CH);

  logic [DATA_W-1:0] holdReg;
  logic [SEL_W-1:0]  selNext;
  logic [MAX_CH-1:0] setMask, clrMask;
  logic              holdWe;
  logic              chanOk, selErr, selFull, selEmpty;
  logic [REG_W-1:0]  statusWord;
  logic              unusedWd;

  assign unusedWd = ^regWdata;
  assign pushData = regWdata[DATA_W-1:0];
  assign chanOk   = (NUM_CH > 0) && (int'(selReg) < NUM_CH);
  assign selErr   = errBits[selReg];
  assign selFull  = d2cFull[selReg];
  assign selEmpty = c2dEmpty[selReg];

  always_comb begin
    statusWord = '0;
    statusWord[ERR_LSB  +: MAX_CH] = errBits;
    statusWord[VAL_LSB  +: MAX_CH] = ~c2dEmpty & CH_MASK;
    statusWord[FULL_LSB +: MAX_CH] = d2cFull & CH_MASK;
    statusWord[SEL_LSB  +: SEL_W]  = selReg;
    statusWord[CNT_LSB  +: CNT_W]  = CNT_VAL;
  end

  always_comb begin
    strb     = '0;
    regRdata = '0;
    regErr   = 1'b0;
    setMask  = '0;
    clrMask  = '0;
    selNext  = selReg;
    holdWe   = 1'b0;
    if (regWrite) begin
      case (regAddr)
        A_CSR: begin
          selNext = regWdata[SEL_LSB +: SEL_W];
          clrMask = regWdata[ERR_LSB +: MAX_CH] & CH_MASK;
        end
        A_TX: begin
          if (NUM_CH == 0) begin
            regErr = 1'b1;
          end else begin
            holdWe = 1'b1;
            if (!chanOk) begin
              regErr = 1'b1;
            end else if (selErr || selFull) begin
              regErr           = 1'b1;
              setMask[selReg]  = 1'b1;
            end else begin
              strb.d2cPush[selReg] = 1'b1;
            end
          end
        end
        default: regErr = 1'b1;
      endcase
    end else if (regRead) begin
      case (regAddr)
        A_CSR: regRdata = statusWord;
        A_TX: begin
          if (NUM_CH == 0) regErr = 1'b1;
          else             regRdata = REG_W'(holdReg);
        end
        A_RX: begin
          if (!chanOk) begin
            regErr = 1'b1;
          end else if (selErr || selEmpty) begin
            regErr          = 1'b1;
            setMask[selReg] = 1'b1;
          end else begin
            regRdata            = REG_W'(c2dHead[selReg]);
            strb.c2dPop[selReg] = 1'b1;
          end
        end
        default: regErr = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= '0;
      holdReg <= '0;
      errBits <= '0;
    end else begin
      selReg  <= selNext;
      if (holdWe) holdReg <= regWdata[DATA_W-1:0];
      errBits <= ((errBits & ~clrMask) | setMask | coreErrEvt) & CH_MASK;
    end
  end

endmodule

// File: rtl/dbgmbx_top.sv
module dbgmbx_top import dbgmbx_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic                                       regWrite,
  input  logic                                       regRead,
  input  logic [1:0]                                 regAddr,
  input  logic [31:0]                                regWdata,
  output logic [31:0]                                regRdata,
  output logic                                       regErr,
  input  logic [(NUM_CH > 0 ? NUM_CH : 1)-1:0]        corePush,
  input  logic [(NUM_CH > 0 ? NUM_CH : 1)*DATA_W-1:0] coreWdata,
  input  logic [(NUM_CH > 0 ? NUM_CH : 1)-1:0]        corePop,
  output logic [(NUM_CH > 0 ? NUM_CH : 1)*DATA_W-1:0] coreRdata,
  output logic [(NUM_CH > 0 ? NUM_CH : 1)-1:0]        coreEmpty,
  output logic [(NUM_CH > 0 ? NUM_CH : 1)-1:0]        coreFull
);

  localparam int CHP = (NUM_CH > 0) ? NUM_CH : 1;

  chStrobe_t                      strb;
  logic [DATA_W-1:0]              pushData;
  logic [MAX_CH-1:0]              errBits;
  logic [SEL_W-1:0]               selReg;
  logic [MAX_CH-1:0]              d2cFull, c2dEmpty, coreErrEvt;
  logic [MAX_CH-1:0][DATA_W-1:0]  c2dHead;

  dbgmbx_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrite   (regWrite),
    .regRead    (regRead),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .regErr     (regErr),
    .d2cFull    (d2cFull),
    .c2dEmpty   (c2dEmpty),
    .c2dHead    (c2dHead),
    .coreErrEvt (coreErrEvt),
    .strb       (strb),
    .pushData   (pushData),
    .errBits    (errBits),
    .selReg     (selReg)
  );

  dbgmbx_data #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .DEPTH(DEPTH), .CHP(CHP)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .pushData   (pushData),
    .corePush   (corePush),
    .coreWdata  (coreWdata),
    .corePop    (corePop),
    .coreRdata  (coreRdata),
    .coreEmpty  (coreEmpty),
    .coreFull   (coreFull),
    .d2cFull    (d2cFull),
    .c2dEmpty   (c2dEmpty),
    .c2dHead    (c2dHead),
    .coreErrEvt (coreErrEvt)
  );

endmodule

// File: rtl/dbgmbx_chk.sv
module dbgmbx_chk import dbgmbx_pkg::*; #(
  parameter int NUM_CH = 8,
  parameter int CHP    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrite,
  input logic              regRead,
  input logic [1:0]        regAddr,
  input logic [7:0]        wdLow,
  input logic [31:0]       regRdata,
  input logic              regErr,
  input logic [CHP-1:0]    corePush,
  input logic [CHP-1:0]    coreFull,
  input logic [CHP-1:0]    coreEmpty,
  input logic [MAX_CH-1:0] errBits,
  input logic [SEL_W-1:0]  selReg,
  input logic [MAX_CH-1:0] d2cFull
);

  localparam logic [MAX_CH-1:0] CH_MASK = MAX_CH'((1 << NUM_CH) - 1);

  logic              chanOk, csrRead, txWrite, rxRead;
  logic [MAX_CH-1:0] clrMask, pushPad, fullPad, emptyPad, ovfEvt, keepMask;

  assign chanOk   = (NUM_CH > 0) && (int'(selReg) < NUM_CH);
  assign csrRead  = regRead && !regWrite && (regAddr == A_CSR);
  assign txWrite  = regWrite && (regAddr == A_TX);
  assign rxRead   = regRead && !regWrite && (regAddr == A_RX);
  assign clrMask  = (regWrite && (regAddr == A_CSR)) ? wdLow : '0;
  assign pushPad  = MAX_CH'(corePush) & CH_MASK;
  assign fullPad  = MAX_CH'(coreFull) & CH_MASK;
  assign emptyPad = MAX_CH'(coreEmpty) & CH_MASK;
  assign ovfEvt   = pushPad & fullPad;
  assign keepMask = errBits & ~clrMask;

  p_tx_reject_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txWrite && chanOk && (errBits[selReg] || d2cFull[selReg])) |-> regErr);

  p_tx_reject_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txWrite && chanOk && (errBits[selReg] || d2cFull[selReg])) |=> errBits[$past(selReg)]);

  p_rx_fail_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && regErr) |-> (regRdata == 32'd0));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|keepMask) |=> ((errBits & $past(keepMask)) == $past(keepMask)));

  p_core_ovf_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|ovfEvt) |=> ((errBits & $past(ovfEvt)) == $past(ovfEvt)));

  p_count_r1: assert property (@(posedge clk) disable iff (!rstN)
    csrRead |-> ((int'(regRdata[CNT_LSB +: CNT_W]) == NUM_CH) && !regErr));

  p_status_flags_r2: assert property (@(posedge clk) disable iff (!rstN)
    csrRead |-> (((regRdata[VAL_LSB +: MAX_CH] & fullPad) == fullPad) &&
                 ((regRdata[FULL_LSB +: MAX_CH] & ~emptyPad) == regRdata[FULL_LSB +: MAX_CH])));

  p_no_chan_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!chanOk && (txWrite || rxRead)) |-> regErr);

endmodule

bind dbgmbx_top dbgmbx_chk #(.NUM_CH(NUM_CH), .CHP(CHP)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrite  (regWrite),
  .regRead   (regRead),
  .regAddr   (regAddr),
  .wdLow     (regWdata[7:0]),
  .regRdata  (regRdata),
  .regErr    (regErr),
  .corePush  (corePush),
  .coreFull  (coreFull),
  .coreEmpty (coreEmpty),
  .errBits   (errBits),
  .selReg    (selReg),
  .d2cFull   (d2cFull)
);

// File: tb/dbgmbx_top_tb.sv
`timescale 1ns/1ps
module dbgmbx_top_tb;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0, regRead = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata, zRdata;
  logic        regErr, zErr;
  logic [N-1:0]   corePush = '0, corePop = '0;
  logic [N*8-1:0] coreWdata = '0;
  logic [N*8-1:0] coreRdata;
  logic [N-1:0]   coreEmpty, coreFull;
  logic [7:0]  zRd;
  logic        zEmpty, zFull;

  always #4 clk = ~clk;

  dbgmbx_top #(.NUM_CH(N), .DATA_W(8), .DEPTH(4)) u_dut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regRead(regRead),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .regErr(regErr),
    .corePush(corePush), .coreWdata(coreWdata), .corePop(corePop),
    .coreRdata(coreRdata), .coreEmpty(coreEmpty), .coreFull(coreFull));

  dbgmbx_top #(.NUM_CH(0), .DATA_W(8), .DEPTH(4)) u_zero (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regRead(regRead),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(zRdata), .regErr(zErr),
    .corePush(1'b0), .coreWdata(8'd0), .corePop(1'b0),
    .coreRdata(zRd), .coreEmpty(zEmpty), .coreFull(zFull));

  int nChecks = 0;
  int nFail   = 0;

  logic [7:0] qD2c [N][$];
  logic [7:0] qC2d [N][$];
  logic [N-1:0] mErr;
  logic [2:0]   mSel;
  logic [7:0]   mHold;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int c = 0; c < N; c++) begin
      qD2c[c].delete();
      qC2d[c].delete();
    end
    mErr  = '0;
    mSel  = '0;
    mHold = '0;
  endtask

  task automatic step(input logic w, input logic r, input logic [1:0] a,
                      input logic [31:0] wd, input logic [N-1:0] pu,
                      input logic [N*8-1:0] pd, input logic [N-1:0] po,
                      input string tag);
    logic [31:0] expRd, st;
    logic        expErr, chOk, doPushD, doPopC, zExp;
    logic [N-1:0] setM, clrM, pushC, popD;
    logic [2:0]  nSel;
    logic [7:0]  nHold;
    @(negedge clk);
    regWrite = w; regRead = r; regAddr = a; regWdata = wd;
    corePush = pu; coreWdata = pd; corePop = po;
    #1;
    expRd = '0; expErr = 1'b0; setM = '0; clrM = '0;
    doPushD = 1'b0; doPopC = 1'b0; nSel = mSel; nHold = mHold;
    chOk = (mSel < 3'(N));
    st = '0;
    st[31:28] = 4'(N);
    st[26:24] = mSel;
    for (int c = 0; c < N; c++) begin
      st[c]      = mErr[c];
      st[8 + c]  = (qC2d[c].size() > 0);
      st[16 + c] = (qD2c[c].size() == 4);
    end
    if (w) begin
      case (a)
        2'd0: begin nSel = wd[26:24]; clrM = wd[N-1:0]; end
        2'd1: begin
          nHold = wd[7:0];
          if (!chOk) expErr = 1'b1;
          else if (mErr[mSel] || qD2c[mSel].size() == 4) begin
            expErr = 1'b1; setM[mSel] = 1'b1;
          end else doPushD = 1'b1;
        end
        default: expErr = 1'b1;
      endcase
    end else if (r) begin
      case (a)
        2'd0: expRd = st;
        2'd1: expRd = {24'd0, mHold};
        2'd2: begin
          if (!chOk) expErr = 1'b1;
          else if (mErr[mSel] || qC2d[mSel].size() == 0) begin
            expErr = 1'b1; setM[mSel] = 1'b1;
          end else begin
            expRd = {24'd0, qC2d[mSel][0]}; doPopC = 1'b1;
          end
        end
        default: expErr = 1'b1;
      endcase
    end
    check(tag, "regErr", {31'd0, regErr}, {31'd0, expErr});
    check(tag, "regRdata", regRdata, expRd);
    for (int c = 0; c < N; c++) begin
      check(tag, $sformatf("coreEmpty[%0d]", c), {31'd0, coreEmpty[c]},
            {31'd0, qD2c[c].size() == 0});
      check(tag, $sformatf("coreFull[%0d]", c), {31'd0, coreFull[c]},
            {31'd0, qC2d[c].size() == 4});
      if (qD2c[c].size() > 0)
        check(tag, $sformatf("coreRdata[%0d]", c), {24'd0, coreRdata[c*8 +: 8]},
              {24'd0, qD2c[c][0]});
    end
    zExp = (w || r) && (a != 2'd0);
    check({tag, " zero-channel"}, "regErr", {31'd0, zErr}, {31'd0, zExp});
    if (r && !w && a == 2'd0)
      check({tag, " zero-channel"}, "status", zRdata & 32'hF0FF_FFFF, 32'd0);
    pushC = '0; popD = '0;
    for (int c = 0; c < N; c++) begin
      if (pu[c]) begin
        if (qC2d[c].size() < 4) pushC[c] = 1'b1; else setM[c] = 1'b1;
      end
      if (po[c]) begin
        if (qD2c[c].size() > 0) popD[c] = 1'b1; else setM[c] = 1'b1;
      end
    end
    for (int c = 0; c < N; c++) begin
      if (popD[c]) void'(qD2c[c].pop_front());
      if (doPopC && int'(mSel) == c) void'(qC2d[c].pop_front());
      if (doPushD && int'(mSel) == c) qD2c[c].push_back(wd[7:0]);
      if (pushC[c]) qC2d[c].push_back(pd[c*8 +: 8]);
    end
    mErr  = (mErr & ~clrM) | setM;
    mSel  = nSel;
    mHold = nHold;
  endtask

  task automatic csrWr(input logic [31:0] v, input string t);
    step(1'b1, 1'b0, 2'd0, v, '0, '0, '0, t);
  endtask
  task automatic txWr(input logic [7:0] d, input string t);
    step(1'b1, 1'b0, 2'd1, {24'd0, d}, '0, '0, '0, t);
  endtask
  task automatic rd(input logic [1:0] a, input string t);
    step(1'b0, 1'b1, a, '0, '0, '0, '0, t);
  endtask
  task automatic core(input logic [N-1:0] pu, input logic [N*8-1:0] pd,
                      input logic [N-1:0] po, input string t);
    step(1'b0, 1'b0, 2'd0, '0, pu, pd, po, t);
  endtask
  function automatic logic [31:0] selWord(input int s, input logic [7:0] clr);
    return (32'(s) << 24) | {24'd0, clr};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    regWrite = 1'b0; regRead = 1'b0; corePush = '0; corePop = '0;
    modelReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    nFail++;
    $display("FAIL watchdog (R11 run): actual timeout expected completion");
    finishRun();
  end

  initial begin
    modelReset();
    doReset();
    // reset state
    rd(2'd0, "R11 reset status");
    rd(2'd1, "R5 reset hold");
    // select field and count
    csrWr(selWord(1, 8'h00), "R1 select write");
    rd(2'd0, "R1 select readback");
    // fill channel 1 and overflow
    txWr(8'hA1, "R3 push");
    txWr(8'hA2, "R3 push");
    txWr(8'hA3, "R3 push");
    txWr(8'hA4, "R3 push");
    rd(2'd0, "R2 full bit");
    txWr(8'hA5, "R4 write to full");
    rd(2'd0, "R2 error bit");
    rd(2'd1, "R5 hold after failed write");
    // core drains in order, then underflows
    core(4'b0010, '0, 4'b0010, "R3 core pop order");
    core(4'b0000, '0, 4'b0010, "R3 core pop order");
    core(4'b0000, '0, 4'b0010, "R3 core pop order");
    core(4'b0000, '0, 4'b0010, "R3 core pop order");
    core(4'b0000, '0, 4'b0010, "R9 pop empty");
    rd(1'b0, "R9 error after underflow");
    txWr(8'hB0, "R4 write with error set");
    core(4'b0000, '0, 4'b0010, "R4 nothing queued");
    // clear semantics
    csrWr(selWord(1, 8'h00), "R8 write 0 keeps flag");
    rd(2'd0, "R8 flag kept");
    csrWr(selWord(1, 8'h02), "R8 write 1 clears");
    rd(2'd0, "R8 flag cleared");
    txWr(8'hB1, "R3 push after clear");
    // core-to-debugger on channel 2
    csrWr(selWord(2, 8'h00), "R1 select 2");
    rd(2'd2, "R7 read empty");
    core(4'b0100, {8'h00, 8'hC1, 8'h00, 8'h00}, 4'b0000, "R7 core push");
    rd(2'd2, "R7 read with flag set");
    csrWr(selWord(2, 8'h04), "R8 clear channel 2");
    core(4'b0100, {8'h00, 8'hC2, 8'h00, 8'h00}, 4'b0000, "R6 core push");
    rd(2'd0, "R2 valid bit");
    rd(2'd2, "R6 oldest first");
    step(1'b0, 1'b1, 2'd2, '0, 4'b0100, {8'h00, 8'hC3, 8'h00, 8'h00}, 4'b0000,
         "R6 read with core push");
    rd(2'd2, "R6 last byte");
    rd(2'd2, "R7 drained");
    csrWr(selWord(2, 8'h04), "R8 clear channel 2");
    // overflow channel 3 from core side
    for (int i = 0; i < 5; i++)
      core(4'b1000, {8'(8'hD0 + i), 24'd0}, 4'b0000, "R9 core push to full");
    rd(2'd0, "R9 overflow flag");
    step(1'b1, 1'b0, 2'd0, selWord(3, 8'h08), 4'b1000, {8'hDF, 24'd0}, 4'b0000,
         "R8 set wins over clear");
    rd(2'd0, "R8 flag still set");
    csrWr(selWord(3, 8'h08), "R8 clear channel 3");
    rd(2'd2, "R6 first of full queue");
    // concurrent traffic on channel 3
    step(1'b1, 1'b0, 2'd1, 32'h0000_00E1, 4'b1000, {8'hE9, 24'd0}, 4'b1000,
         "R3 tx write with core pop on empty");
    csrWr(selWord(3, 8'h08), "R8 clear channel 3");
    txWr(8'hE2, "R3 push");
    step(1'b1, 1'b0, 2'd1, 32'h0000_00E3, 4'b0000, '0, 4'b1000, "R3 push with pop");
    // missing channel and unmapped accesses
    csrWr(selWord(5, 8'h00), "R10 select out of range");
    txWr(8'hF0, "R10 tx to missing channel");
    rd(2'd2, "R10 rx from missing channel");
    rd(2'd0, "R10 no flags changed");
    rd(2'd3, "R10 unmapped read");
    step(1'b1, 1'b0, 2'd3, 32'h1, '0, '0, '0, "R10 unmapped write");
    step(1'b1, 1'b0, 2'd2, 32'h1, '0, '0, '0, "R10 receive write");
    rd(2'd1, "R5 hold after missing channel write");
    // mid-run reset with queues holding data
    csrWr(selWord(0, 8'h00), "R1 select 0");
    txWr(8'h11, "R3 push");
    core(4'b0001, {24'd0, 8'h22}, 4'b0000, "R9 core push");
    doReset();
    rd(2'd0, "R11 status after reset");
    core(4'b0000, '0, 4'b0000, "R11 queues empty");
    rd(2'd2, "R11 nothing to receive");
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule